// File: doc/BRIEF.md
# Lockstep Commit Coordinator for Fused Reorder Buffers

This block lets the reorder buffers of several small cores retire as one logical reorder buffer when the cores are fused. Each cycle, every core reports three things about the head of its reorder buffer. The first is how many entries are complete at the head. The second is whether the oldest entry is still unfinished. The third is, per head slot, whether the entry is a padding no-op. From these reports the coordinator computes a commit count that is the same for every member of a fused group. It also asks cores whose head is empty to take padding no-ops, and it raises a group-wide hold when any member is blocked.

The decisions pass through a one-cycle pre-commit register before they reach the cores. This gives the signals between cores a whole cycle to travel. A two-bit fusion mode selects how the cores are grouped. In mode 0 each core is alone and commits by itself. Mode 1 forms groups of two cores. Mode 2 or higher forms one group of all cores. In the unfused case the logic reduces to passing each core's own count straight back to it.

Top module: `lsc_commit_coord`

## Requirements
- R1: Every output reflects the inputs sampled at the previous rising clock edge. The outputs stay unchanged between edges.
- R2: In a fused group with no blocked member, each member's commit count equals the smallest ready count reported in that group. Ready counts are binary values from 0 to SLOTS, with SLOTS=2 by default.
- R3: If any member of a group reports a blocked head, every member of that group gets commit count 0 and no-op request 0, and has its hold output at 1.
- R4: In a group with no blocked member, a member whose ready count is 0 gets a no-op request equal to the largest ready count in its group. Every other member gets a no-op request of 0.
- R5: Effect bit c*SLOTS+s is 1 exactly when slot s of core c commits (s is less than that core's commit count) and that slot's no-op flag, bit c*SLOTS+s, was 0.
- R6: In mode 0 each core forms its own group. It commits its own ready count unless it is itself blocked, and it never receives no-op requests.
- R7: Mode 1 forms the groups {0,1} and {2,3}. Modes 2 and 3 put all four cores in one group. A core outside a group is never affected by that group's status.
- R8: While reset is high at a clock edge, every commit count, no-op request, effect bit and hold output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_mode | input | 2 | Grouping: 0 alone, 1 pairs, 2 or 3 all cores |
| hd_cnt | input | CORES*CW | Per-core count of complete head entries, CW bits each |
| hd_stall | input | CORES | Per-core flag: oldest head entry not finished |
| hd_nop | input | CORES*SLOTS | Per-core, per-slot padding no-op flag |
| cm_cnt | output | CORES*CW | Per-core entries to commit this cycle |
| cm_effect | output | CORES*SLOTS | Per-core, per-slot committed entry with architectural effect |
| nop_req | output | CORES*CW | Per-core number of padding no-ops to insert |
| grp_hold | output | CORES | Per-core hold because a group member is blocked |

## Verification
The assertions assume that every reported ready count is at most SLOTS. They compare outputs only with inputs sampled on a clock edge after reset was released. The random stimulus draws each count from 0 to SLOTS. It makes a blocked head less likely than a ready one, so that commit, padding and hold all occur often. Directed cases add boundary cases on top of the random ones. These are all counts at the maximum, one empty member among full ones, a block in one pair that must not reach the other pair, mode 3 behaving like mode 2, and reset asserted during traffic.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int MODE_W = 2;
  typedef logic [MODE_W-1:0] fuse_mode_t;

  // log2 of the group size for a mode, clamped to the whole core set
  function automatic int grp_shift(input fuse_mode_t m, input int log2_cores);
    int v;
    v = int'(m);
    return (v > log2_cores) ? log2_cores : v;
  endfunction
endpackage

// File: rtl/lsc_group_scan.sv
module lsc_group_scan
  import lsc_pkg::*;
#(
  parameter int CORES = 4,
  parameter int SLOTS = 2,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int LOG2C = $clog2(CORES)
) (
  input  fuse_mode_t            mode,
  input  logic [CORES*CW-1:0]   cnt_flat,
  input  logic [CORES-1:0]      stall,
  output logic [CORES-1:0]      g_stall,
  output logic [CORES*CW-1:0]   g_min,
  output logic [CORES*CW-1:0]   g_max
);
  always_comb begin
    int sh;
    sh = grp_shift(mode, LOG2C);
    g_stall = '0;
    g_min   = '0;
    g_max   = '0;
    for (int c = 0; c < CORES; c++) begin
      logic          st;
      logic [CW-1:0] mn;
      logic [CW-1:0] mx;
      st = 1'b0;
      mn = CW'(SLOTS);
      mx = '0;
      for (int j = 0; j < CORES; j++) begin
        if ((j >> sh) == (c >> sh)) begin
          st = st | stall[j];
          if (cnt_flat[j*CW +: CW] < mn) mn = cnt_flat[j*CW +: CW];
          if (cnt_flat[j*CW +: CW] > mx) mx = cnt_flat[j*CW +: CW];
        end
      end
      g_stall[c]         = st;
      g_min[c*CW +: CW]  = mn;
      g_max[c*CW +: CW]  = mx;
    end
  end
endmodule

// File: rtl/lsc_precommit.sv
module lsc_precommit #(
  parameter int SLOTS = 2,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             g_stall,
  input  logic [CW-1:0]    g_min,
  input  logic [CW-1:0]    g_max,
  input  logic [CW-1:0]    own_cnt,
  input  logic [SLOTS-1:0] own_nop,
  output logic [CW-1:0]    cm_cnt,
  output logic [SLOTS-1:0] cm_effect,
  output logic [CW-1:0]    nop_req,
  output logic             hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cm_cnt    <= '0;
      cm_effect <= '0;
      nop_req   <= '0;
      hold      <= 1'b0;
    end else begin
      hold    <= g_stall;
      cm_cnt  <= g_stall ? '0 : g_min;
      nop_req <= (!g_stall && own_cnt == '0) ? g_max : '0;
      for (int s = 0; s < SLOTS; s++)
        cm_effect[s] <= !g_stall && (CW'(s) < g_min) && !own_nop[s];
    end
  end

  // an effect bit never appears beyond the committed slots
  AST_EFFECT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cm_cnt == '0) |-> (cm_effect == '0)); // R5
endmodule

// File: rtl/lsc_commit_coord.sv
module lsc_commit_coord
  import lsc_pkg::*;
#(
  parameter int CORES = 4,
  parameter int SLOTS = 2,
  localparam int CW = $clog2(SLOTS + 1),
  localparam int LOG2C = $clog2(CORES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [MODE_W-1:0]      fuse_mode,
  input  logic [CORES*CW-1:0]    hd_cnt,
  input  logic [CORES-1:0]       hd_stall,
  input  logic [CORES*SLOTS-1:0] hd_nop,
  output logic [CORES*CW-1:0]    cm_cnt,
  output logic [CORES*SLOTS-1:0] cm_effect,
  output logic [CORES*CW-1:0]    nop_req,
  output logic [CORES-1:0]       grp_hold
);
  logic [CORES-1:0]    g_stall;
  logic [CORES*CW-1:0] g_min;
  logic [CORES*CW-1:0] g_max;

  lsc_group_scan #(.CORES(CORES), .SLOTS(SLOTS)) u_scan (
    .mode     (fuse_mode),
    .cnt_flat (hd_cnt),
    .stall    (hd_stall),
    .g_stall  (g_stall),
    .g_min    (g_min),
    .g_max    (g_max)
  );

  for (genvar c = 0; c < CORES; c++) begin : g_core
    lsc_precommit #(.SLOTS(SLOTS)) u_pre (
      .clk       (clk),
      .rst       (rst),
      .g_stall   (g_stall[c]),
      .g_min     (g_min[c*CW +: CW]),
      .g_max     (g_max[c*CW +: CW]),
      .own_cnt   (hd_cnt[c*CW +: CW]),
      .own_nop   (hd_nop[c*SLOTS +: SLOTS]),
      .cm_cnt    (cm_cnt[c*CW +: CW]),
      .cm_effect (cm_effect[c*SLOTS +: SLOTS]),
      .nop_req   (nop_req[c*CW +: CW]),
      .hold      (grp_hold[c])
    );

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
      grp_hold[c] |-> (cm_cnt[c*CW +: CW] == '0 && nop_req[c*CW +: CW] == '0)); // R3

    AST_OWN_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(hd_stall[c])) |-> grp_hold[c]); // R3

    AST_NOP_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && nop_req[c*CW +: CW] != '0) |-> ($past(hd_cnt[c*CW +: CW]) == '0)); // R4

    AST_SPLIT_PASS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(fuse_mode) == '0 && !$past(hd_stall[c]))
      |-> (cm_cnt[c*CW +: CW] == $past(hd_cnt[c*CW +: CW]) && nop_req[c*CW +: CW] == '0)); // R6

    AST_COMMIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst)) |-> (cm_cnt[c*CW +: CW] <= $past(hd_cnt[c*CW +: CW]))); // R2

    if (c > 0) begin : g_eq
      AST_FUSED_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int'($past(fuse_mode)) >= LOG2C)
        |-> (cm_cnt[c*CW +: CW] == cm_cnt[CW-1:0] && grp_hold[c] == grp_hold[0])); // R7
    end
  end

  AST_FULL_READY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hd_stall) == '0 && $past(hd_cnt) == {CORES{CW'(SLOTS)}})
    |-> (cm_cnt == {CORES{CW'(SLOTS)}})); // R1
endmodule

// File: tb/test_lsc_commit_coord.sv
`timescale 1ns/1ps
module test_lsc_commit_coord;
  localparam int N = 4;
  localparam int W = 2;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] fuse_mode;
  logic [N*CW-1:0] hd_cnt;
  logic [N-1:0] hd_stall;
  logic [N*W-1:0] hd_nop;
  logic [N*CW-1:0] cm_cnt;
  logic [N*W-1:0] cm_effect;
  logic [N*CW-1:0] nop_req;
  logic [N-1:0] grp_hold;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  int in_cnt [N];
  bit in_stl [N];
  bit in_nop [N][W];
  int ex_cnt [N];
  int ex_inj [N];
  bit ex_hold [N];
  bit ex_eff [N][W];

  always #2 clk = ~clk;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      hd_cnt[c*CW +: CW] = CW'(in_cnt[c]);
      hd_stall[c] = in_stl[c];
      for (int s = 0; s < W; s++) hd_nop[c*W+s] = in_nop[c][s];
    end
  end

  lsc_commit_coord i_lsc_commit_coord (
    .clk(clk), .rst(rst), .fuse_mode(fuse_mode), .hd_cnt(hd_cnt),
    .hd_stall(hd_stall), .hd_nop(hd_nop), .cm_cnt(cm_cnt),
    .cm_effect(cm_effect), .nop_req(nop_req), .grp_hold(grp_hold)
  );

  function automatic int group_of(int c, logic [1:0] m);
    if (m == 2'd0) return c;
    if (m == 2'd1) return c / 2;
    return 0;
  endfunction

  function automatic void predict();
    for (int c = 0; c < N; c++) begin
      bit blk = 0;
      int lo = W;
      int hi = 0;
      for (int j = 0; j < N; j++) begin
        if (group_of(j, fuse_mode) == group_of(c, fuse_mode)) begin
          if (in_stl[j]) blk = 1;
          if (in_cnt[j] < lo) lo = in_cnt[j];
          if (in_cnt[j] > hi) hi = in_cnt[j];
        end
      end
      ex_hold[c] = blk;
      ex_cnt[c] = blk ? 0 : lo;
      ex_inj[c] = (!blk && in_cnt[c] == 0) ? hi : 0;
      for (int s = 0; s < W; s++) ex_eff[c][s] = !blk && (s < lo) && !in_nop[c][s];
    end
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < N; c++) begin
      string rc = (tag != "") ? tag : ((fuse_mode == 2'd0) ? "R6" : "R2");
      chk(rc, $sformatf("cm_cnt[%0d]", c), int'(cm_cnt[c*CW +: CW]), ex_cnt[c]);
      chk("R4", $sformatf("nop_req[%0d]", c), int'(nop_req[c*CW +: CW]), ex_inj[c]);
      chk("R3", $sformatf("grp_hold[%0d]", c), int'(grp_hold[c]), int'(ex_hold[c]));
      for (int s = 0; s < W; s++)
        chk("R5", $sformatf("cm_effect[%0d]", c*W+s), int'(cm_effect[c*W+s]), int'(ex_eff[c][s]));
    end
  endtask

  // called at a falling edge: drive, confirm no change before the edge, then check after it
  task automatic apply(string tag);
    logic [N*CW-1:0] prev_cnt;
    prev_cnt = cm_cnt;
    predict();
    #1;
    chk("R1", "cm_cnt before edge", int'(cm_cnt), int'(prev_cnt));
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic set_core(int c, int n, bit st, bit n0, bit n1);
    in_cnt[c] = n; in_stl[c] = st; in_nop[c][0] = n0; in_nop[c][1] = n1;
  endtask

  task automatic check_zero(string req);
    chk(req, "cm_cnt", int'(cm_cnt), 0);
    chk(req, "nop_req", int'(nop_req), 0);
    chk(req, "cm_effect", int'(cm_effect), 0);
    chk(req, "grp_hold", int'(grp_hold), 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    fuse_mode = 2'd2;
    for (int c = 0; c < N; c++) set_core(c, 2, 0, 0, 0);
    repeat (3) @(negedge clk);
    check_zero("R8");
    rst = 1'b0;

    // R1: all ready at maximum in quad mode
    fuse_mode = 2'd2;
    for (int c = 0; c < N; c++) set_core(c, 2, 0, 0, 1);
    apply("R1");

    // R4: one empty member among full ones gets padding of the max count
    set_core(2, 0, 0, 0, 0);
    apply("R4");

    // R3: a single blocked core holds the whole fused group
    for (int c = 0; c < N; c++) set_core(c, 2, 0, 0, 0);
    in_stl[3] = 1;
    apply("R3");

    // R7: block in pair {0,1} leaves pair {2,3} committing
    fuse_mode = 2'd1;
    set_core(0, 2, 1, 0, 0); set_core(1, 1, 0, 0, 0);
    set_core(2, 2, 0, 1, 0); set_core(3, 1, 0, 0, 0);
    apply("R7");

    // R7: mode 3 groups like mode 2
    fuse_mode = 2'd3;
    set_core(0, 2, 0, 0, 0); set_core(1, 1, 0, 0, 0);
    set_core(2, 2, 0, 0, 0); set_core(3, 2, 0, 0, 0);
    apply("R7");

    // R6: split mode passes own counts, own stall only
    fuse_mode = 2'd0;
    set_core(0, 0, 0, 0, 0); set_core(1, 2, 0, 1, 1);
    set_core(2, 1, 1, 0, 0); set_core(3, 2, 0, 0, 0);
    apply("R6");

    // R5: no-op flags strip effect bits on committed slots
    fuse_mode = 2'd2;
    for (int c = 0; c < N; c++) set_core(c, 2, 0, c[0], c[1]);
    apply("R5");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      fuse_mode = 2'($urandom_range(0, 3));
      for (int c = 0; c < N; c++)
        set_core(c, int'($urandom_range(0, W)), ($urandom_range(0, 5) == 0),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      apply("");
    end

    // R8: reset during traffic clears outputs
    for (int c = 0; c < N; c++) set_core(c, 2, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    check_zero("R8");
    rst = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule